// File: doc/BRIEF.md
# Flag-Accurate 8-Bit Accumulator ALU

This block is the arithmetic and logic unit of a small 8-bit accumulator processor. Each cycle it may be handed an operation code, a register-side operand, a memory-side operand and the processor's current carry flag. It computes a data result and new negative (N), overflow (V), zero (Z) and carry (C) flags. Each operation writes only the flags that its rules allow.

A single strobe, `in_valid`, loads the result and the permitted flags into an output register stage. Flags that an operation does not touch keep their latched value. The result register is written only by operations that produce a write-back value. Compare and bit test leave it alone and report this on `res_wr_q`.

Subtraction and compare treat carry as an inverted borrow, so C = 1 means that no borrow occurred. Bit test takes N and V straight from the memory operand. A logical right shift always clears N.

Top module: `alu8_flags`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `res_q`, `res_wr_q`, `out_valid_q` and all four flag outputs are 0.
- R2: Operation code 0 (add) latches R = (reg + mem + carry_in) mod 256 and writes all four flags. C is the carry out of bit 7. V is 1 when both operands have equal sign bits and the sign bit of R differs from them.
- R3: Operation code 1 (subtract) latches R = (reg − mem − (1 − carry_in)) mod 256 and writes all four flags. C is 1 when no borrow occurred. V is 1 when the operands differ in sign and the sign bit of R differs from that of reg.
- R4: Operation code 2 (compare) writes N and Z from (reg − mem) mod 256 and sets C = (reg ≥ mem unsigned). It keeps V and `res_q`, and latches `res_wr_q` = 0.
- R5: Operation codes 3, 4 and 5 (AND, OR, XOR of reg and mem) latch the result and write N and Z only. C and V are kept.
- R6: Operation code 6 (bit test) sets Z when (reg AND mem) is zero, and copies mem bit 7 into N and mem bit 6 into V. It keeps C and `res_q`, and latches `res_wr_q` = 0.
- R7: Operation code 7 shifts reg left, with 0 entering bit 0 and bit 7 going to C. Operation code 8 shifts reg right, with 0 entering bit 7, bit 0 going to C and N forced to 0. Both write N, Z and C.
- R8: Operation code 9 rotates reg left, with carry_in entering bit 0 and bit 7 going to C. Operation code 10 rotates reg right, with carry_in entering bit 7 and bit 0 going to C. Both write N, Z and C.
- R9: Operation codes 11 and 12 latch mem + 1 and mem − 1 (mod 256). They write N and Z only, and keep C and V.
- R10: `out_valid_q` is 1 exactly in the cycle after a cycle with `in_valid` high. Without `in_valid`, `res_q` and all flags hold, and `res_wr_q` is 0.
- R11: Operation codes 13 to 15 change neither the result nor any flag. They still pulse `out_valid_q`, with `res_wr_q` = 0.
- R12: For every written-back result, N equals result bit 7 (except for the right shift, which forces N to 0) and Z is 1 exactly when the latched result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe that loads the output stage |
| op | input | 4 | Operation code |
| reg_opd | input | 8 | Register-side operand |
| mem_opd | input | 8 | Memory-side operand |
| carry_in | input | 1 | Current carry flag |
| res_q | output | 8 | Latched result |
| res_wr_q | output | 1 | Latched operation produces a write-back value |
| out_valid_q | output | 1 | Output stage was loaded on the last edge |
| flag_n_q | output | 1 | Negative flag |
| flag_v_q | output | 1 | Overflow flag |
| flag_z_q | output | 1 | Zero flag |
| flag_c_q | output | 1 | Carry flag |

## Verification
The block has one register stage, so every result, flag and valid bit appears on the edge that follows the strobed cycle. Inputs are driven on the falling edge. The outputs are compared on the next falling edge against a behavioural model that was updated when those inputs were applied, so each comparison falls half a cycle after the edge where the design latched its values. Idle cycles and unused operation codes are compared in the same way, which confirms that the held flags and the held result did not move. Directed corner cases come first, covering signed overflow, wrap to zero, borrow, equal compare and shifts out of both ends. A long random run with random strobes follows.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_AND = 4'd3,
    OP_OR  = 4'd4,  OP_XOR = 4'd5,  OP_BIT = 4'd6,  OP_SHL = 4'd7,
    OP_SHR = 4'd8,  OP_ROL = 4'd9,  OP_ROR = 4'd10, OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  localparam int NFLAGS = 4;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   m,
  input  logic            cin,
  output logic [DW-1:0]   sum,
  output logic            cout,
  output logic            ovf
);
  localparam int MSB = DW - 1;

  function automatic logic [DW:0] add_c(input logic [DW-1:0] x,
                                        input logic [DW-1:0] y,
                                        input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
  endfunction

  function automatic logic sign_ovf(input logic [DW-1:0] x,
                                    input logic [DW-1:0] y,
                                    input logic [DW-1:0] s);
    return (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  logic [DW-1:0] opx, opy;
  logic          opc;
  logic [DW:0]   full;

  always_comb begin
    opx = a;
    opy = m;
    opc = cin;
    case (op)
      OP_SUB: begin opy = ~m; end
      OP_CMP: begin opy = ~m; opc = 1'b1; end
      OP_INC: begin opx = m; opy = '0;  opc = 1'b1; end
      OP_DEC: begin opx = m; opy = '1;  opc = 1'b0; end
      default: ;
    endcase
  end

  assign full = add_c(opx, opy, opc);
  assign sum  = full[DW-1:0];
  assign cout = full[DW];
  assign ovf  = sign_ovf(opx, opy, full[DW-1:0]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   m,
  output logic [DW-1:0]   res
);
  always_comb begin
    case (op)
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      default: res = a & m;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op,
  input  logic [DW-1:0]   a,
  input  logic            cin,
  output logic [DW-1:0]   res,
  output logic            cout
);
  localparam int MSB = DW - 1;

  always_comb begin
    case (op)
      OP_SHL:  begin res = {a[MSB-1:0], 1'b0}; cout = a[MSB]; end
      OP_SHR:  begin res = {1'b0, a[MSB:1]};   cout = a[0];   end
      OP_ROL:  begin res = {a[MSB-1:0], cin};  cout = a[MSB]; end
      OP_ROR:  begin res = {cin, a[MSB:1]};    cout = a[0];   end
      default: begin res = a;                  cout = cin;    end
    endcase
  end
endmodule

// File: rtl/alu8_outreg.sv
module alu8_outreg
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            res_we,
  input  logic [DW-1:0]   res_d,
  input  flags_t          flag_we,
  input  flags_t          flag_d,
  output logic [DW-1:0]   res_q,
  output logic            wr_q,
  output logic            vld_q,
  output flags_t          flag_q
);
  logic [NFLAGS-1:0] we_v, d_v, q_v;
  assign we_v   = flag_we;
  assign d_v    = flag_d;
  assign flag_q = q_v;

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q_v[i] <= 1'b0;
      else if (load && we_v[i])  q_v[i] <= d_v[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= load;
      wr_q  <= load && res_we;
      if (load && res_we) res_q <= res_d;
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [DW-1:0]   reg_opd,
  input  logic [DW-1:0]   mem_opd,
  input  logic            carry_in,
  output logic [DW-1:0]   res_q,
  output logic            res_wr_q,
  output logic            out_valid_q,
  output logic            flag_n_q,
  output logic            flag_v_q,
  output logic            flag_z_q,
  output logic            flag_c_q
);
  localparam int MSB = DW - 1;

  alu_op_e       op_e;
  logic [DW-1:0] arith_sum, logic_res, shift_res, nxt_res;
  logic          arith_cout, arith_ovf, shift_cout, res_we;
  flags_t        flag_we, nxt_flags, flags_q;

  assign op_e = alu_op_e'(op);

  alu8_arith #(.DW(DW)) u_arith (
    .op(op_e), .a(reg_opd), .m(mem_opd), .cin(carry_in),
    .sum(arith_sum), .cout(arith_cout), .ovf(arith_ovf));

  alu8_logic #(.DW(DW)) u_logic (
    .op(op_e), .a(reg_opd), .m(mem_opd), .res(logic_res));

  alu8_shift #(.DW(DW)) u_shift (
    .op(op_e), .a(reg_opd), .cin(carry_in),
    .res(shift_res), .cout(shift_cout));

  always_comb begin
    nxt_res   = arith_sum;
    res_we    = 1'b0;
    flag_we   = '0;
    nxt_flags = '0;
    case (op_e)
      OP_ADD, OP_SUB: begin
        res_we    = 1'b1;
        flag_we   = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
        nxt_flags = '{n: arith_sum[MSB], v: arith_ovf,
                      z: (arith_sum == '0), c: arith_cout};
      end
      OP_CMP: begin
        flag_we   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
        nxt_flags = '{n: arith_sum[MSB], v: 1'b0,
                      z: (arith_sum == '0), c: arith_cout};
      end
      OP_AND, OP_OR, OP_XOR: begin
        nxt_res   = logic_res;
        res_we    = 1'b1;
        flag_we   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        nxt_flags = '{n: logic_res[MSB], v: 1'b0,
                      z: (logic_res == '0), c: 1'b0};
      end
      OP_BIT: begin
        flag_we   = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
        nxt_flags = '{n: mem_opd[MSB], v: mem_opd[MSB-1],
                      z: (logic_res == '0), c: 1'b0};
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        nxt_res   = shift_res;
        res_we    = 1'b1;
        flag_we   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
        nxt_flags = '{n: (op_e == OP_SHR) ? 1'b0 : shift_res[MSB], v: 1'b0,
                      z: (shift_res == '0), c: shift_cout};
      end
      OP_INC, OP_DEC: begin
        res_we    = 1'b1;
        flag_we   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
        nxt_flags = '{n: arith_sum[MSB], v: 1'b0,
                      z: (arith_sum == '0), c: 1'b0};
      end
      default: ;
    endcase
  end

  alu8_outreg #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(in_valid), .res_we(res_we),
    .res_d(nxt_res), .flag_we(flag_we), .flag_d(nxt_flags),
    .res_q(res_q), .wr_q(res_wr_q), .vld_q(out_valid_q), .flag_q(flags_q));

  assign flag_n_q = flags_q.n;
  assign flag_v_q = flags_q.v;
  assign flag_z_q = flags_q.z;
  assign flag_c_q = flags_q.c;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    op,
  input logic [DW-1:0] reg_opd,
  input logic [DW-1:0] mem_opd,
  input logic [DW-1:0] res_q,
  input logic          res_wr_q,
  input logic          out_valid_q,
  input logic          flag_n_q,
  input logic          flag_v_q,
  input logic          flag_z_q,
  input logic          flag_c_q
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid_q) else $error("valid pulse missing"); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid_q && !res_wr_q && $stable(res_q) && $stable(flag_n_q)
                   && $stable(flag_v_q) && $stable(flag_z_q) && $stable(flag_c_q)))
    else $error("idle cycle changed outputs"); // R10
  AST_CMP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd2) |=> (!res_wr_q && $stable(res_q) && $stable(flag_v_q)))
    else $error("compare disturbed result or V"); // R4
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd3 || op == 4'd4 || op == 4'd5)) |=> ($stable(flag_c_q) && $stable(flag_v_q)))
    else $error("logic op touched C or V"); // R5
  AST_BIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6) |=> (flag_n_q == $past(mem_opd[DW-1]) && flag_v_q == $past(mem_opd[DW-2])
                                  && $stable(flag_c_q) && $stable(res_q)))
    else $error("bit test flags wrong"); // R6
  AST_SHR_CLEARS_N: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd8) |=> (!flag_n_q && flag_c_q == $past(reg_opd[0])))
    else $error("right shift flags wrong"); // R7
  AST_INCDEC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd11 || op == 4'd12)) |=> ($stable(flag_c_q) && $stable(flag_v_q)))
    else $error("inc/dec touched C or V"); // R9
  AST_UNUSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 4'd12) |=> (!res_wr_q && $stable(res_q) && $stable(flag_n_q)
                                  && $stable(flag_v_q) && $stable(flag_z_q) && $stable(flag_c_q)))
    else $error("unused code changed state"); // R11
  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_q && res_wr_q) |-> (flag_z_q == (res_q == '0)))
    else $error("Z disagrees with result"); // R12
endmodule

bind alu8_flags alu8_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .reg_opd(reg_opd), .mem_opd(mem_opd), .res_q(res_q), .res_wr_q(res_wr_q),
  .out_valid_q(out_valid_q), .flag_n_q(flag_n_q), .flag_v_q(flag_v_q),
  .flag_z_q(flag_z_q), .flag_c_q(flag_c_q));

// File: tb/tb_alu8_flags.sv
`timescale 1ns/1ps
module tb_alu8_flags;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] reg_opd = '0, mem_opd = '0;
  logic       carry_in = 1'b0;
  logic [7:0] res_q;
  logic       res_wr_q, out_valid_q, flag_n_q, flag_v_q, flag_z_q, flag_c_q;

  int checks = 0;
  int errors = 0;

  int ex_res = 0;
  bit ex_wr = 0, ex_vld = 0, ex_n = 0, ex_v = 0, ex_z = 0, ex_c = 0;
  string ex_tag = "R1";

  always #2.5 clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .reg_opd(reg_opd), .mem_opd(mem_opd), .carry_in(carry_in),
    .res_q(res_q), .res_wr_q(res_wr_q), .out_valid_q(out_valid_q),
    .flag_n_q(flag_n_q), .flag_v_q(flag_v_q), .flag_z_q(flag_z_q), .flag_c_q(flag_c_q));

  function automatic string tag_of(input bit v, input int o);
    if (!v) return "R10";
    case (o)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      6: return "R6";
      7, 8: return "R7";
      9, 10: return "R8";
      11, 12: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (res_q !== 8'(ex_res) || res_wr_q !== ex_wr || out_valid_q !== ex_vld ||
        flag_n_q !== ex_n || flag_v_q !== ex_v || flag_z_q !== ex_z || flag_c_q !== ex_c) begin
      errors++;
      $display("FAIL %s: got res=%02h wr=%0b vld=%0b NVZC=%0b%0b%0b%0b expected res=%02h wr=%0b vld=%0b NVZC=%0b%0b%0b%0b",
               ex_tag, res_q, res_wr_q, out_valid_q, flag_n_q, flag_v_q, flag_z_q, flag_c_q,
               ex_res, ex_wr, ex_vld, ex_n, ex_v, ex_z, ex_c);
    end
    if (out_valid_q && res_wr_q) begin
      checks++;  // R12: Z reflects written-back result
      if (flag_z_q !== (res_q == 8'h00)) begin
        errors++;
        $display("FAIL R12: got Z=%0b expected %0b for res=%02h", flag_z_q, res_q == 8'h00, res_q);
      end
    end
  endtask

  task automatic model(input bit v, input int o, input int a, input int m, input int c);
    int t, r;
    ex_tag = tag_of(v, o);
    ex_vld = v;
    ex_wr  = 0;
    if (!v) return;
    r = ex_res;
    case (o)
      0: begin t = a + m + c; r = t % 256; ex_c = (t > 255);
               ex_v = (((a ^ r) & (m ^ r) & 128) != 0); ex_wr = 1; end
      1: begin t = a - m - (1 - c); r = (t + 512) % 256; ex_c = (t >= 0);
               ex_v = (((a ^ m) & (a ^ r) & 128) != 0); ex_wr = 1; end
      2: begin t = (a - m + 256) % 256; ex_c = (a >= m);
               ex_n = (t >= 128); ex_z = (t == 0); end
      3: begin r = a & m; ex_wr = 1; end
      4: begin r = a | m; ex_wr = 1; end
      5: begin r = a ^ m; ex_wr = 1; end
      6: begin ex_z = ((a & m) == 0); ex_n = (m >= 128); ex_v = ((m / 64) % 2 == 1); end
      7: begin r = (a * 2) % 256; ex_c = (a >= 128); ex_wr = 1; end
      8: begin r = a / 2; ex_c = (a % 2 == 1); ex_wr = 1; end
      9: begin r = (a * 2 + c) % 256; ex_c = (a >= 128); ex_wr = 1; end
      10: begin r = a / 2 + c * 128; ex_c = (a % 2 == 1); ex_wr = 1; end
      11: begin r = (m + 1) % 256; ex_wr = 1; end
      12: begin r = (m + 255) % 256; ex_wr = 1; end
      default: ;
    endcase
    if (ex_wr) begin
      ex_res = r;
      ex_n = (r >= 128);
      ex_z = (r == 0);
    end
  endtask

  task automatic step(input bit v, input int o, input int a, input int m, input int c);
    @(negedge clk);
    compare();
    in_valid = v;
    op       = 4'(o);
    reg_opd  = 8'(a);
    mem_opd  = 8'(m);
    carry_in = c[0];
    model(v, o, a, m, c);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R10: got watchdog timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1: outputs while reset is held
    if ({res_q, res_wr_q, out_valid_q, flag_n_q, flag_v_q, flag_z_q, flag_c_q} !== 14'h0) begin
      errors++;
      $display("FAIL R1: got res=%02h NVZC=%0b%0b%0b%0b expected all zero",
               res_q, flag_n_q, flag_v_q, flag_z_q, flag_c_q);
    end
    rst_n = 1'b1;
    ex_tag = "R1";
    // R2: signed overflow, then carry-out wrap to zero
    step(1, 0, 8'h7F, 8'h01, 0);
    step(1, 0, 8'hFF, 8'h01, 0);
    step(1, 0, 8'h10, 8'h20, 1);
    // R3: overflow on subtract, borrow to FF
    step(1, 1, 8'h80, 8'h01, 1);
    step(1, 1, 8'h00, 8'h00, 0);
    // R4: equal and less-than compares
    step(1, 2, 8'h42, 8'h42, 0);
    step(1, 2, 8'h10, 8'h20, 1);
    // R5
    step(1, 3, 8'hF0, 8'h0F, 1);
    step(1, 4, 8'h80, 8'h01, 0);
    step(1, 5, 8'hAA, 8'hAA, 0);
    // R6: bit test with disjoint operands
    step(1, 6, 8'h3F, 8'hC0, 0);
    step(1, 6, 8'h01, 8'h01, 0);
    // R7
    step(1, 7, 8'h80, 8'h00, 0);
    step(1, 8, 8'h81, 8'h00, 0);
    // R8
    step(1, 9, 8'h80, 8'h00, 0);
    step(1, 10, 8'h01, 8'h00, 1);
    // R9: wrap both directions
    step(1, 11, 8'h00, 8'hFF, 0);
    step(1, 12, 8'h00, 8'h00, 1);
    // R10: idle cycles hold
    step(0, 0, 8'h55, 8'h55, 1);
    step(0, 7, 8'hFF, 8'hFF, 1);
    // R11: unused codes
    step(1, 13, 8'h12, 8'h34, 1);
    step(1, 15, 8'h00, 8'h00, 0);
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, 15), $urandom_range(0, 255),
           $urandom_range(0, 255), $urandom_range(0, 1));
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule